// File: doc/BRIEF.md
# Serial Port Register Front End

This block sits between a simple CPU bus and the bit-level parts of an asynchronous serial port. One bus address carries characters in both directions. A write to it fills a single transmit holding buffer. A read of it returns the oldest character waiting in a small receive queue, and each such read removes that character from the queue. A second address returns the status flags. A third address holds the enables, the character size and the interrupt enables.

On the transmit side, the holding buffer hands its byte to a shift register whenever the transmitter is enabled and the shift register is idle. The shift register then sends one frame on the serial output, advancing one bit on each baud tick. On the receive side, an external receiver presents complete characters through a one-cycle valid strobe, and the block queues them.

The block raises three interrupt requests: receive complete, transmit complete and buffer empty. Parity, baud generation and receive oversampling are handled elsewhere. The parity-error status bit always reads zero.

Top module: `usart_regs_top`

## Requirements
- R1: After reset, status (address 1) reads 0x20, control (address 2) reads 0x0C, `txd` is high and all three interrupt requests are low.
- R2: A data write (address 0) while the buffer-empty flag (status bit 5) is set loads the holding buffer and clears that flag. A data write while the flag is clear is dropped, and the held byte is kept.
- R3: When transmit is enabled (control bit 0), the shift register is idle and the holding buffer is full, the byte moves into the shift register one cycle after it was written. From that cycle the buffer-empty flag is set again and `txd` drives the start bit.
- R4: Each frame is one low start bit, then N data bits least significant first, then one high stop bit. Bits advance only on `baud_tick`, and `txd` is high when no frame is in progress.
- R5: Control bits 3:2 hold a size code c, with N = 5 + c (the reset value 3 gives 8 bits). The transmitter sends only the low N bits of the byte. Received characters are stored with bits above N forced to zero.
- R6: Transmit-complete (status bit 6) is set when a stop bit ends and the holding buffer is empty. It is cleared by a status write with bit 6 = 1, or by a pulse on `irq_txc_ack`. A status write with bit 6 = 0 leaves it unchanged.
- R7: The receive queue holds two characters and returns them oldest first. Every data read removes the head entry. A read of an empty queue returns 0 and changes nothing.
- R8: Receive-complete (status bit 7) is high exactly when the queue is not empty. Frame-error (status bit 4) shows the error flag stored with the head character.
- R9: A character that arrives while the queue is full and no read is under way is discarded, and data-overrun (status bit 3) is set. The next data read clears data-overrun.
- R10: While receive is disabled (control bit 1 = 0), the queue is flushed and incoming characters are ignored, so receive-complete reads 0.
- R11: `irq_rx`, `irq_txc` and `irq_udre` follow receive-complete, transmit-complete and buffer-empty, each gated by its enable in control bits 7, 6 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register select: 0 data, 1 status, 2 control |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; pops the receive queue at address 0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| baud_tick | input | 1 | One-cycle bit-time strobe |
| rx_valid | input | 1 | Received character is present this cycle |
| rx_char | input | 8 | Received character |
| rx_ferr | input | 1 | Frame error of the received character |
| irq_txc_ack | input | 1 | Transmit-complete interrupt acknowledge |
| txd | output | 1 | Serial output |
| irq_rx | output | 1 | Receive-complete interrupt request |
| irq_txc | output | 1 | Transmit-complete interrupt request |
| irq_udre | output | 1 | Buffer-empty interrupt request |

## Verification
The bench builds the block with its defaults: a two-entry receive queue and a two-bit address. With only two entries, a third back-to-back character is enough to reach the overrun and discard path. The bench produces a baud tick every fourth clock, so 5-bit and 8-bit frames finish within a few dozen cycles. This makes back-to-back frames, the dropped write while the buffer is full and the transmit-complete timing cheap to reach in a single run.

// File: rtl/usart_regs_pkg.sv
// Shared register layout and character-size helpers for the serial port front end.
// Assumes an 8-bit data path and a two-bit size code selecting 5..8 bits.
package usart_regs_pkg;

    localparam int DATA_W = 8;

    // register addresses
    localparam int REG_DATA = 0;
    localparam int REG_STAT = 1;
    localparam int REG_CTRL = 2;

    // status bit positions
    localparam int ST_RXC  = 7;
    localparam int ST_TXC  = 6;
    localparam int ST_UDRE = 5;
    localparam int ST_FE   = 4;
    localparam int ST_DOR  = 3;

    // control bit positions
    localparam int CT_TXEN    = 0;
    localparam int CT_RXEN    = 1;
    localparam int CT_SZ_LO   = 2;
    localparam int CT_IE_UDRE = 5;
    localparam int CT_IE_TXC  = 6;
    localparam int CT_IE_RX   = 7;

    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h0C;

    // mask keeping the low 5+code bits of a character
    function automatic logic [DATA_W-1:0] char_mask(input logic [1:0] code);
        return 8'hFF >> (3'd3 - {1'b0, code});
    endfunction

    // number of data bits for a size code
    function automatic logic [3:0] char_bits(input logic [1:0] code);
        return 4'd5 + {2'b00, code};
    endfunction

endpackage

// File: rtl/usart_tx_path.sv
// Transmit holding buffer plus framing shift register.
// Assumes baud_tick is a one-cycle strobe; the frame is start, N data bits LSB first, stop.
module usart_tx_path
    import usart_regs_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_buf,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tx_en,
    input  logic [1:0]        size_code,
    input  logic              baud_tick,
    output logic              txd,
    output logic              buf_empty,
    output logic              frame_done
);

    localparam int FRAME_W = DATA_W + 2;

    logic [DATA_W-1:0]  tx_buf;
    logic               buf_full;
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   bits_left;
    logic               busy;
    logic               load;
    logic [FRAME_W-1:0] frame_word;
    logic [CNT_W-1:0]   nbits;

    assign nbits     = CNT_W'(char_bits(size_code));
    assign load      = tx_en && !busy && buf_full;
    assign buf_empty = !buf_full;
    assign txd       = busy ? shreg[0] : 1'b1;
    assign frame_done = busy && baud_tick && (bits_left == CNT_W'(1)) && !buf_full;

    // Build the frame: stop fill above the data, masked data, start bit at bit 0
    always_comb begin
        frame_word = ({FRAME_W{1'b1}} << (nbits + CNT_W'(1)))
                   | {1'b0, tx_buf & char_mask(size_code), 1'b0};
    end

    // Holding buffer: accept writes only when empty, release on load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf   <= '0;
            buf_full <= 1'b0;
        end else if (wr_buf && !buf_full) begin
            tx_buf   <= wdata;
            buf_full <= 1'b1;
        end else if (load) begin
            buf_full <= 1'b0;
        end
    end

    // Shift register: load a frame, then shift one bit per baud tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '1;
            bits_left <= '0;
            busy      <= 1'b0;
        end else if (load) begin
            shreg     <= frame_word;
            bits_left <= nbits + CNT_W'(2);
            busy      <= 1'b1;
        end else if (busy && baud_tick) begin
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - CNT_W'(1);
            if (bits_left == CNT_W'(1)) busy <= 1'b0;
        end
    end

    // R2: a write to a full buffer keeps the held byte
    assert_drop_when_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_buf && buf_full) |=> $stable(tx_buf));

    // R3: a load always leaves the buffer empty on the next cycle
    assert_empty_after_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> buf_empty);

    // R4: line idles high between frames
    assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

endmodule

// File: rtl/usart_rx_fifo.sv
// Receive queue: DEPTH entries, pop returns oldest; pushes to a full queue are dropped
// and reported through a one-cycle overrun pulse. Assumes flush has priority over all.
module usart_rx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic             empty,
    output logic             overrun
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             pop_ok, push_ok, full;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign pop_ok  = pop && !empty;
    assign push_ok = push && (!full || pop_ok);
    assign overrun = push && !push_ok && !flush;
    assign dout    = mem[rd_ptr];

    // advance a pointer with wrap at DEPTH
    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    // Storage write for accepted pushes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push_ok && !flush) begin
            mem[wr_ptr] <= din;
        end
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
            else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
        end
    end

    // R7: occupancy never exceeds the depth
    assert_count_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    // R9: a dropped push leaves the queue full
    assert_overrun_keeps_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> full);

    // R10: a flush always empties the queue
    assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/usart_regs_top.sv
// Register front end of an asynchronous serial port: shared data address, status,
// control and interrupt requests. Assumes single-cycle bus strobes; read data is
// combinational from the address, and a data read pops at the clock edge.
module usart_regs_top
    import usart_regs_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int RX_DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              baud_tick,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_char,
    input  logic              rx_ferr,
    input  logic              irq_txc_ack,
    output logic              txd,
    output logic              irq_rx,
    output logic              irq_txc,
    output logic              irq_udre
);

    localparam int ENTRY_W = DATA_W + 1;

    logic [DATA_W-1:0]  ctrl_q;
    logic               txc_q, dor_q;
    logic               sel_data, sel_stat, sel_ctrl;
    logic               data_rd, data_wr;
    logic               udre, frame_done;
    logic               rx_empty, rx_ovf, rxc, fe;
    logic [ENTRY_W-1:0] rx_head, rx_entry;
    logic [DATA_W-1:0]  status;

    assign sel_data = (bus_addr == ADDR_W'(REG_DATA));
    assign sel_stat = (bus_addr == ADDR_W'(REG_STAT));
    assign sel_ctrl = (bus_addr == ADDR_W'(REG_CTRL));
    assign data_rd  = bus_rd && sel_data;
    assign data_wr  = bus_wr && sel_data;
    assign rx_entry = {rx_ferr, rx_char & char_mask(ctrl_q[CT_SZ_LO +: 2])};

    usart_tx_path u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_buf     (data_wr),
        .wdata      (bus_wdata),
        .tx_en      (ctrl_q[CT_TXEN]),
        .size_code  (ctrl_q[CT_SZ_LO +: 2]),
        .baud_tick  (baud_tick),
        .txd        (txd),
        .buf_empty  (udre),
        .frame_done (frame_done)
    );

    usart_rx_fifo #(.WIDTH(ENTRY_W), .DEPTH(RX_DEPTH)) u_rxq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!ctrl_q[CT_RXEN]),
        .push    (rx_valid && ctrl_q[CT_RXEN]),
        .din     (rx_entry),
        .pop     (data_rd),
        .dout    (rx_head),
        .empty   (rx_empty),
        .overrun (rx_ovf)
    );

    assign rxc    = !rx_empty;
    assign fe     = rxc && rx_head[DATA_W];
    assign status = {rxc, txc_q, udre, fe, dor_q, 3'b000};

    // Control register: plain read/write
    always_ff @(posedge clk) begin
        if (!rst_n)                   ctrl_q <= CTRL_RESET;
        else if (bus_wr && sel_ctrl)  ctrl_q <= bus_wdata;
    end

    // Transmit-complete flag: set at frame end, cleared by write-one or acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            txc_q <= 1'b0;
        else if (frame_done)
            txc_q <= 1'b1;
        else if (irq_txc_ack || (bus_wr && sel_stat && bus_wdata[ST_TXC]))
            txc_q <= 1'b0;
    end

    // Overrun flag: set on a dropped character, cleared by a data read or a flush
    always_ff @(posedge clk) begin
        if (!rst_n || !ctrl_q[CT_RXEN]) dor_q <= 1'b0;
        else if (rx_ovf)                dor_q <= 1'b1;
        else if (data_rd)               dor_q <= 1'b0;
    end

    // Read data multiplexer
    always_comb begin
        bus_rdata = '0;
        if (sel_data)      bus_rdata = rx_empty ? '0 : rx_head[DATA_W-1:0];
        else if (sel_stat) bus_rdata = status;
        else if (sel_ctrl) bus_rdata = ctrl_q;
    end

    assign irq_rx   = rxc   && ctrl_q[CT_IE_RX];
    assign irq_txc  = txc_q && ctrl_q[CT_IE_TXC];
    assign irq_udre = udre  && ctrl_q[CT_IE_UDRE];

    // R6: transmit-complete only rises while the holding buffer was empty
    assert_txc_needs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(txc_q) |-> $past(udre));

    // R9: a data read without a new overrun clears the overrun flag
    assert_dor_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !rx_ovf) |=> !dor_q);

    // R6: a status write of zero with no frame end keeps transmit-complete
    assert_txc_write_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel_stat && !bus_wdata[ST_TXC] && !irq_txc_ack && !frame_done)
        |=> $stable(txc_q));

endmodule

// File: tb/usart_regs_top_test.sv
module usart_regs_top_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       baud_tick = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_char = '0;
    logic       rx_ferr = 1'b0;
    logic       irq_txc_ack = 1'b0;
    logic       txd, irq_rx, irq_txc, irq_udre;

    int n_checks = 0;
    int n_fail   = 0;
    logic [11:0] exp_q[$];   // {nbits, masked byte}

    always #5 clk = ~clk;

    usart_regs_top uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
        .rx_valid(rx_valid), .rx_char(rx_char), .rx_ferr(rx_ferr),
        .irq_txc_ack(irq_txc_ack), .txd(txd), .irq_rx(irq_rx), .irq_txc(irq_txc),
        .irq_udre(irq_udre)
    );

    // baud tick every fourth clock, driven away from the active edge
    int tick_cnt = 0;
    always @(negedge clk) begin
        tick_cnt  = (tick_cnt + 1) % 4;
        baud_tick = (tick_cnt == 3);
    end

    task automatic check_eq(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] c, input logic fe);
        @(negedge clk);
        rx_valid = 1'b1; rx_char = c; rx_ferr = fe;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    // driver: wait for buffer-empty, queue the expectation, write the byte
    task automatic send_byte(input logic [7:0] b, input int n);
        logic [7:0] s;
        do bus_read(2'd1, s); while (!s[5]);
        exp_q.push_back({4'(n), b & 8'((1 << n) - 1)});
        bus_write(2'd0, b);
    endtask

    task automatic wait_txc();
        logic [7:0] s;
        int guard = 0;
        do begin bus_read(2'd1, s); guard++; end while (!s[6] && guard < 2000);
    endtask

    task automatic wait_tick();
        do @(posedge clk); while (!baud_tick);
        @(negedge clk);
    endtask

    // monitor: capture serial frames and compare against the queue (R4, R5)
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !txd) begin
                logic [11:0] e;
                logic [7:0]  got;
                int n;
                if (exp_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL R2 unexpected frame actual=1 expected=0");
                    e = {4'd8, 8'h00};
                end else e = exp_q.pop_front();
                n   = int'(e[11:8]);
                got = '0;
                for (int i = 0; i < n; i++) begin
                    wait_tick();
                    got[i] = txd;
                end
                check_eq("R4 R5 frame data", got, e[7:0]);
                wait_tick();
                check_eq("R4 stop bit", {7'b0, txd}, 8'h01);
            end
            prev = txd;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd1, v); check_eq("R1 status reset", v, 8'h20);
        bus_read(2'd2, v); check_eq("R1 control reset", v, 8'h0C);
        check_eq("R1 txd idle", {7'b0, txd}, 8'h01);
        check_eq("R1 irqs", {5'b0, irq_rx, irq_txc, irq_udre}, 8'h00);

        bus_write(2'd2, 8'hEF);
        check_eq("R11 irq_udre enabled", {7'b0, irq_udre}, 8'h01);
        check_eq("R11 irq_rx idle", {7'b0, irq_rx}, 8'h00);

        // R2/R3 write then load timing
        exp_q.push_back({4'd8, 8'hA5});
        bus_write(2'd0, 8'hA5);
        check_eq("R2 empty flag cleared", {7'b0, irq_udre}, 8'h00);
        @(negedge clk);
        check_eq("R3 empty flag restored", {7'b0, irq_udre}, 8'h01);
        check_eq("R3 start bit", {7'b0, txd}, 8'h00);
        send_byte(8'h3C, 8);
        send_byte(8'h81, 8);
        wait_txc();
        bus_read(2'd1, v); check_eq("R6 txc set", {7'b0, v[6]}, 8'h01);
        check_eq("R11 irq_txc", {7'b0, irq_txc}, 8'h01);
        bus_write(2'd1, 8'h00);
        bus_read(2'd1, v); check_eq("R6 write zero keeps", {7'b0, v[6]}, 8'h01);
        bus_write(2'd1, 8'h40);
        bus_read(2'd1, v); check_eq("R6 write one clears", {7'b0, v[6]}, 8'h00);

        // R2 dropped write while full
        bus_write(2'd2, 8'hEE);
        bus_write(2'd0, 8'h55);
        bus_read(2'd1, v); check_eq("R2 full flag", {7'b0, v[5]}, 8'h00);
        bus_write(2'd0, 8'hAA);
        exp_q.push_back({4'd8, 8'h55});
        bus_write(2'd2, 8'hEF);
        wait_txc();
        @(negedge clk); irq_txc_ack = 1'b1;
        @(negedge clk); irq_txc_ack = 1'b0;
        bus_read(2'd1, v); check_eq("R6 ack clears", {7'b0, v[6]}, 8'h00);

        // R5 five-bit transmit
        bus_write(2'd2, 8'hE3);
        send_byte(8'hCA, 5);
        wait_txc();

        // R5 six-bit receive masking
        bus_write(2'd2, 8'hE7);
        push_rx(8'hFF, 1'b0);
        bus_read(2'd0, v); check_eq("R5 rx masked", v, 8'h3F);

        // R7/R8 queue order and flags
        bus_write(2'd2, 8'hEF);
        push_rx(8'h11, 1'b0);
        push_rx(8'h22, 1'b1);
        bus_read(2'd1, v); check_eq("R8 rxc/fe", {6'b0, v[7], v[4]}, 8'h02);
        check_eq("R11 irq_rx", {7'b0, irq_rx}, 8'h01);
        bus_read(2'd0, v); check_eq("R7 first", v, 8'h11);
        bus_read(2'd1, v); check_eq("R8 fe head", {6'b0, v[7], v[4]}, 8'h03);
        bus_read(2'd0, v); check_eq("R7 second", v, 8'h22);
        bus_read(2'd1, v); check_eq("R8 rxc empty", {7'b0, v[7]}, 8'h00);
        bus_read(2'd0, v); check_eq("R7 empty read", v, 8'h00);
        push_rx(8'h66, 1'b0);
        bus_read(2'd0, v); check_eq("R7 after empty read", v, 8'h66);

        // R9 overrun
        push_rx(8'h31, 1'b0);
        push_rx(8'h32, 1'b0);
        push_rx(8'h33, 1'b0);
        bus_read(2'd1, v); check_eq("R9 dor set", {7'b0, v[3]}, 8'h01);
        bus_read(2'd0, v); check_eq("R9 oldest kept", v, 8'h31);
        bus_read(2'd1, v); check_eq("R9 dor cleared", {7'b0, v[3]}, 8'h00);
        bus_read(2'd0, v); check_eq("R9 second kept", v, 8'h32);
        bus_read(2'd1, v); check_eq("R9 third dropped", {7'b0, v[7]}, 8'h00);

        // R10 flush and ignore while disabled
        push_rx(8'h44, 1'b0);
        bus_write(2'd2, 8'hED);
        bus_read(2'd1, v); check_eq("R10 flushed", {7'b0, v[7]}, 8'h00);
        push_rx(8'h55, 1'b0);
        bus_write(2'd2, 8'hEF);
        bus_read(2'd1, v); check_eq("R10 ignored", {7'b0, v[7]}, 8'h00);
        bus_read(2'd0, v); check_eq("R10 data empty", v, 8'h00);

        repeat (100) @(negedge clk);
        check_eq("R4 all frames seen", 8'(exp_q.size()), 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule